// File: doc/BRIEF.md
# Post-Increment Load Unit

This unit executes one load with base write-back at a time on a 64-bit datapath. A decoded operation arrives carrying an access size, a signed flag, an update-mode selection, a displacement field, the base register value and the index register value. The memory read goes out at the base value as it stood before the operation. No offset is added to form the address. The offset is applied only to the copy of the base that is written back.

When the little-endian memory returns its 64-bit response word, the unit picks out the addressed byte lanes and extends the result to 64 bits. It then presents the loaded value and the new base together on a single write-back handshake. A slow memory therefore also delays the base update. If the destination register and the base register are the same, only the base write is enabled, and a conflict flag is raised.

Top module: `pul_unit`

## Requirements
- R1: The memory address equals `req_base` as captured at acceptance, with no offset added, and it stays stable while `mem_req_valid` waits for `mem_req_ready`.
- R2: With `req_indexed`=0 and `req_dsform`=0, `wb_base` = old base + the 16-bit `req_disp` sign-extended to 64 bits, wrapping modulo 2^64.
- R3: With `req_indexed`=1, `wb_base` = old base + the 64-bit `req_index`, wrapping modulo 2^64, and `req_dsform` and `req_disp` have no effect.
- R4: With `req_indexed`=0 and `req_dsform`=1, the displacement is `req_disp[15:2]` with two zero bits appended below it, then sign-extended, and `req_disp[1:0]` is ignored.
- R5: With `req_signed`=0, sizes byte (`req_size`=0), halfword (1) and word (2) put the loaded bytes in the low bits of `wb_data` and fill every higher bit with zero.
- R6: With `req_signed`=1, halfword and word loads sign-extend to 64 bits. For byte loads the flag is ignored and the result is zero-filled.
- R7: A doubleword load (`req_size`=3) returns all eight response bytes unchanged, whatever the value of `req_signed`.
- R8: Memory is little-endian. The value is taken from the response word starting at byte lane `addr[2:0]`, and accesses are assumed to be naturally aligned.
- R9: `wb_valid` rises only on the cycle after the memory response is taken. It stays high until `wb_ready`, and `wb_data` and `wb_base` stay stable meanwhile.
- R10: If `wb_rt` equals `wb_ra`, then `wb_conflict`=1 and `wb_rt_en`=0, so the base update wins. Otherwise `wb_conflict`=0 and `wb_rt_en`=1.
- R11: `req_ready` is high after reset and only while no operation is outstanding. A request offered at any other time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Operation offered |
| req_ready | output | 1 | Unit idle, operation accepted |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_signed | input | 1 | Sign-extend halfword and word |
| req_indexed | input | 1 | Update by index register |
| req_dsform | input | 1 | Scaled 14-bit displacement form |
| req_disp | input | 16 | Displacement field |
| req_base | input | 64 | Base register value |
| req_index | input | 64 | Index register value |
| req_rt | input | 5 | Destination register number |
| req_ra | input | 5 | Base register number |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_addr | output | 64 | Byte address of the read |
| mem_rsp_valid | input | 1 | Response data valid |
| mem_rsp_ready | output | 1 | Unit waiting for response |
| mem_rsp_data | input | 64 | Response word |
| wb_valid | output | 1 | Write-back pair valid |
| wb_ready | input | 1 | Write-back accepted |
| wb_data | output | 64 | Extended loaded value |
| wb_rt | output | 5 | Destination register number |
| wb_rt_en | output | 1 | Destination write enabled |
| wb_base | output | 64 | Updated base value |
| wb_ra | output | 5 | Base register number |
| wb_conflict | output | 1 | Destination equals base register |

## Verification
Two results meet in the same cycle: the extracted and extended load value, and the updated base, which share one write-back handshake. When the destination and base register numbers match, the two results also compete for the same register. The bench provokes both cases with random and directed operations, including equal register numbers, and with random stalls on the request, response and write-back handshakes. While a stall lasts it also offers foreign requests. On each write-back it checks both values against functions that model the size, sign, lane and update-mode rules. It also checks that nothing leaks out before the response is taken, and that the pair stays stable until it is taken.

// File: rtl/pul_pkg.sv
// Shared types for the post-increment load unit.
// Assumes a byte-addressed, little-endian memory.
package pul_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } ld_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_WB    = 2'd3
    } ld_state_e;

endpackage

// File: rtl/pul_base_update.sv
// Computes the written-back base value: the old base plus either the
// index register, the sign-extended displacement, or the scaled 14-bit
// displacement (low two field bits replaced by zeros).
// Assumes XLEN > DISP_W. Purely combinational.
module pul_base_update #(
    parameter int XLEN   = 64,
    parameter int DISP_W = 16
) (
    input  logic [XLEN-1:0]   base,
    input  logic [XLEN-1:0]   index,
    input  logic [DISP_W-1:0] disp,
    input  logic              indexed,
    input  logic              dsform,
    output logic [XLEN-1:0]   new_base
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] disp_plain;
    logic [XLEN-1:0] disp_scaled;
    logic [XLEN-1:0] addend;

    // Sign-extend the displacement in its two encodings.
    always_comb begin
        disp_plain  = {{EXT_W{disp[DISP_W-1]}}, disp};
        disp_scaled = {{EXT_W{disp[DISP_W-1]}}, disp[DISP_W-1:2], 2'b00};
    end

    // Select the addend by update mode and add it to the old base.
    always_comb begin
        if (indexed)
            addend = index;
        else if (dsform)
            addend = disp_scaled;
        else
            addend = disp_plain;
        new_base = base + addend;
    end
endmodule

// File: rtl/pul_lane_extract.sv
// Extracts the addressed bytes from a little-endian response word and
// zero- or sign-extends them. The signed flag only applies to halfword
// and word. Assumes natural alignment and XLEN = 64. Combinational.
module pul_lane_extract
    import pul_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int OFS_W = $clog2(XLEN / 8)
) (
    input  logic [XLEN-1:0]  word,
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       size,
    input  logic             sgn,
    output logic [XLEN-1:0]  value
);
    logic [XLEN-1:0] shifted;
    logic            ext_h;
    logic            ext_w;

    // Bring the addressed lane down to bit 0.
    always_comb shifted = word >> {ofs, 3'b000};

    // Extension bits for the signed sizes.
    always_comb begin
        ext_h = sgn & shifted[15];
        ext_w = sgn & shifted[31];
    end

    // Mask and extend according to the access size.
    always_comb begin
        case (ld_size_e'(size))
            SZ_BYTE: value = {{(XLEN-8){1'b0}}, shifted[7:0]};
            SZ_HALF: value = {{(XLEN-16){ext_h}}, shifted[15:0]};
            SZ_WORD: value = {{(XLEN-32){ext_w}}, shifted[31:0]};
            default: value = shifted;
        endcase
    end
endmodule

// File: rtl/pul_ctrl.sv
// Sequencer for one outstanding load: accept, issue the read, wait for
// the response, then hold the write-back pair until it is taken.
// Assumes the response never arrives before the request handshake.
module pul_ctrl
    import pul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    input  logic wb_ready,
    output logic req_ready,
    output logic mem_req_valid,
    output logic mem_rsp_ready,
    output logic wb_valid,
    output logic accept,
    output logic rsp_take
);
    ld_state_e state_q;
    ld_state_e state_d;

    // Handshake outputs decoded from the state.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        mem_rsp_ready = (state_q == ST_WAIT);
        wb_valid      = (state_q == ST_WB);
        accept        = req_ready & req_valid;
        rsp_take      = mem_rsp_ready & mem_rsp_valid;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (req_valid)     state_d = ST_ISSUE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_WB;
            ST_WB:    if (wb_ready)      state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/pul_unit.sv
// Post-increment load unit top. Reads memory at the un-updated base,
// extracts and extends the loaded value, and returns it together with
// the updated base on one write-back handshake. Destination equal to
// base gives the base priority and raises a conflict flag.
// Assumes naturally aligned accesses and XLEN = 64.
module pul_unit
    import pul_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int DISP_W = 16,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic              req_indexed,
    input  logic              req_dsform,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [XLEN-1:0]   req_base,
    input  logic [XLEN-1:0]   req_index,
    input  logic [RIDX_W-1:0] req_rt,
    input  logic [RIDX_W-1:0] req_ra,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_addr,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [XLEN-1:0]   mem_rsp_data,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [XLEN-1:0]   wb_data,
    output logic [RIDX_W-1:0] wb_rt,
    output logic              wb_rt_en,
    output logic [XLEN-1:0]   wb_base,
    output logic [RIDX_W-1:0] wb_ra,
    output logic              wb_conflict
);
    localparam int OFS_W = $clog2(XLEN / 8);

    logic              accept;
    logic              rsp_take;
    logic [XLEN-1:0]   upd_base;
    logic [XLEN-1:0]   ext_value;

    logic [XLEN-1:0]   addr_q;
    logic [XLEN-1:0]   new_base_q;
    logic [XLEN-1:0]   data_q;
    logic [1:0]        size_q;
    logic              sgn_q;
    logic [RIDX_W-1:0] rt_q;
    logic [RIDX_W-1:0] ra_q;

    pul_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .wb_ready      (wb_ready),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_rsp_ready (mem_rsp_ready),
        .wb_valid      (wb_valid),
        .accept        (accept),
        .rsp_take      (rsp_take)
    );

    pul_base_update #(.XLEN(XLEN), .DISP_W(DISP_W)) u_update (
        .base     (req_base),
        .index    (req_index),
        .disp     (req_disp),
        .indexed  (req_indexed),
        .dsform   (req_dsform),
        .new_base (upd_base)
    );

    pul_lane_extract #(.XLEN(XLEN), .OFS_W(OFS_W)) u_extract (
        .word  (mem_rsp_data),
        .ofs   (addr_q[OFS_W-1:0]),
        .size  (size_q),
        .sgn   (sgn_q),
        .value (ext_value)
    );

    // Capture the operation at acceptance; the address is the old base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            new_base_q <= '0;
            size_q     <= 2'd0;
            sgn_q      <= 1'b0;
            rt_q       <= '0;
            ra_q       <= '0;
        end else if (accept) begin
            addr_q     <= req_base;
            new_base_q <= upd_base;
            size_q     <= req_size;
            sgn_q      <= req_signed;
            rt_q       <= req_rt;
            ra_q       <= req_ra;
        end
    end

    // Register the extended value when the response is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (rsp_take) data_q <= ext_value;
    end

    // Drive the memory address and the write-back pair.
    always_comb begin
        mem_addr    = addr_q;
        wb_data     = data_q;
        wb_base     = new_base_q;
        wb_rt       = rt_q;
        wb_ra       = ra_q;
        wb_conflict = (rt_q == ra_q);
        wb_rt_en    = ~wb_conflict;
    end
endmodule

// File: rtl/pul_unit_chk.sv
// Protocol and result checker for pul_unit, attached by bind.
// Tracks each accepted operation and relates it to the write-back.
module pul_unit_chk #(
    parameter int XLEN   = 64,
    parameter int DISP_W = 16,
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_size,
    input logic              req_signed,
    input logic              req_indexed,
    input logic              req_dsform,
    input logic [DISP_W-1:0] req_disp,
    input logic [XLEN-1:0]   req_base,
    input logic [XLEN-1:0]   req_index,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [XLEN-1:0]   mem_addr,
    input logic              mem_rsp_valid,
    input logic              mem_rsp_ready,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [XLEN-1:0]   wb_data,
    input logic [RIDX_W-1:0] wb_rt,
    input logic              wb_rt_en,
    input logic [XLEN-1:0]   wb_base,
    input logic [RIDX_W-1:0] wb_ra,
    input logic              wb_conflict
);
    logic [1:0]        c_size;
    logic              c_sgn;
    logic              c_idx;
    logic              c_ds;
    logic [XLEN-1:0]   c_base;
    logic [XLEN-1:0]   c_index;
    logic [DISP_W-1:0] c_disp;

    // Track the fields of the accepted operation.
    always_ff @(posedge clk) begin
        if (req_valid && req_ready) begin
            c_size  <= req_size;
            c_sgn   <= req_signed;
            c_idx   <= req_indexed;
            c_ds    <= req_dsform;
            c_base  <= req_base;
            c_index <= req_index;
            c_disp  <= req_disp;
        end
    end

    assert_addr_old_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid && mem_addr == $past(req_base)));

    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

    assert_imm_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !c_idx && !c_ds) |->
        (wb_base == c_base + {{(XLEN-DISP_W){c_disp[DISP_W-1]}}, c_disp}));

    assert_idx_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && c_idx) |-> (wb_base == c_base + c_index));

    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && c_size == 2'd0) |-> (wb_data[XLEN-1:8] == '0));

    assert_sign_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && c_size == 2'd1 && c_sgn) |->
        (wb_data[XLEN-1:16] == {(XLEN-16){wb_data[15]}}));

    assert_wb_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && mem_rsp_ready) |=> wb_valid);

    assert_wb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=>
        (wb_valid && $stable(wb_data) && $stable(wb_base)));

    assert_conflict_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ((wb_conflict == (wb_rt == wb_ra)) && (wb_rt_en != wb_conflict)));

    assert_single_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({req_ready, mem_req_valid, mem_rsp_ready, wb_valid}) == 1);
endmodule

bind pul_unit pul_unit_chk #(.XLEN(XLEN), .DISP_W(DISP_W), .RIDX_W(RIDX_W)) u_pul_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_size      (req_size),
    .req_signed    (req_signed),
    .req_indexed   (req_indexed),
    .req_dsform    (req_dsform),
    .req_disp      (req_disp),
    .req_base      (req_base),
    .req_index     (req_index),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .wb_valid      (wb_valid),
    .wb_ready      (wb_ready),
    .wb_data       (wb_data),
    .wb_rt         (wb_rt),
    .wb_rt_en      (wb_rt_en),
    .wb_base       (wb_base),
    .wb_ra         (wb_ra),
    .wb_conflict   (wb_conflict)
);

// File: tb/tb_pul_unit.sv
module tb_pul_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic        req_indexed = 1'b0;
    logic        req_dsform = 1'b0;
    logic [15:0] req_disp = '0;
    logic [63:0] req_base = '0;
    logic [63:0] req_index = '0;
    logic [4:0]  req_rt = '0;
    logic [4:0]  req_ra = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [63:0] mem_rsp_data = '0;
    logic        wb_valid;
    logic        wb_ready = 1'b0;
    logic [63:0] wb_data;
    logic [4:0]  wb_rt;
    logic        wb_rt_en;
    logic [63:0] wb_base;
    logic [4:0]  wb_ra;
    logic        wb_conflict;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pul_unit dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Expected loaded value from the size, sign and lane rules (R5..R8).
    function automatic logic [63:0] f_load(input logic [63:0] w, input logic [2:0] o,
                                           input logic [1:0] sz, input bit s);
        logic [63:0] sh;
        sh = w >> (8 * o);
        case (sz)
            2'd0: return {56'd0, sh[7:0]};
            2'd1: return s ? {{48{sh[15]}}, sh[15:0]} : {48'd0, sh[15:0]};
            2'd2: return s ? {{32{sh[31]}}, sh[31:0]} : {32'd0, sh[31:0]};
            default: return sh;
        endcase
    endfunction

    // Expected new base from the update-mode rules (R2..R4).
    function automatic logic [63:0] f_base(input logic [63:0] b, input logic [63:0] ix,
                                           input logic [15:0] d, input bit idx, input bit ds);
        if (idx) return b + ix;
        if (ds)  return b + {{48{d[15]}}, d[15:2], 2'b00};
        return b + {{48{d[15]}}, d};
    endfunction

    task automatic run_op(input logic [1:0] sz, input bit sg, input bit idx, input bit ds,
                          input logic [15:0] d, input logic [63:0] b, input logic [63:0] ix,
                          input logic [4:0] rt, input logic [4:0] ra, input logic [63:0] w,
                          input int st_req, input int st_rsp, input int st_wb);
        logic [63:0] e_data;
        logic [63:0] e_base;
        e_data = f_load(w, b[2:0], sz, sg);
        e_base = f_base(b, ix, d, idx, ds);
        req_valid = 1'b1; req_size = sz; req_signed = sg; req_indexed = idx;
        req_dsform = ds; req_disp = d; req_base = b; req_index = ix;
        req_rt = rt; req_ra = ra;
        chk(req_ready == 1'b1, "R11 idle ready", 64'(req_ready), 64'd1);
        @(negedge clk);
        // Offer a foreign request while busy; it must not be taken (R11).
        req_base = ~b; req_index = ~ix; req_disp = ~d; req_rt = ~rt;
        chk(req_ready == 1'b0, "R11 busy not ready", 64'(req_ready), 64'd0);
        chk(mem_req_valid && mem_addr == b, "R1 address", mem_addr, b);
        for (int i = 0; i < st_req; i++) begin
            @(negedge clk);
            chk(mem_req_valid && mem_addr == b, "R1 address held", mem_addr, b);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int i = 0; i < st_rsp; i++) begin
            chk(wb_valid == 1'b0, "R9 no early write-back", 64'(wb_valid), 64'd0);
            mem_rsp_data = {$urandom, $urandom};
            @(negedge clk);
        end
        chk(mem_rsp_ready == 1'b1, "R9 waiting for response", 64'(mem_rsp_ready), 64'd1);
        mem_rsp_valid = 1'b1; mem_rsp_data = w;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = {$urandom, $urandom};
        req_valid = 1'b0;
        for (int i = 0; i <= st_wb; i++) begin
            chk(wb_valid == 1'b1, "R9 write-back valid", 64'(wb_valid), 64'd1);
            chk(wb_data == e_data, "R5-7 data R8 lanes", wb_data, e_data);
            chk(wb_base == e_base, "R2/R3/R4 base", wb_base, e_base);
            chk(wb_rt == rt && wb_ra == ra, "R11 fields kept", {wb_rt, wb_ra}, {rt, ra});
            chk(wb_conflict == (rt == ra), "R10 conflict", 64'(wb_conflict), 64'(rt == ra));
            chk(wb_rt_en == (rt != ra), "R10 target enable", 64'(wb_rt_en), 64'(rt != ra));
            if (i < st_wb) @(negedge clk);
        end
        wb_ready = 1'b1;
        @(negedge clk);
        wb_ready = 1'b0;
        chk(wb_valid == 1'b0 && req_ready == 1'b1, "R11 back to idle",
            {wb_valid, req_ready}, 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(req_ready && !mem_req_valid && !mem_rsp_ready && !wb_valid,
            "R11 reset idle", {req_ready, mem_req_valid, mem_rsp_ready, wb_valid}, 64'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: byte in every lane, negative pattern, R6 signed flag ignored on bytes.
        for (int l = 0; l < 8; l++)
            run_op(2'd0, 1'b1, 1'b0, 1'b0, 16'h0001, 64'h1000 + 64'(l), 64'd0, 5'd3, 5'd4,
                   64'h8877_6655_4433_2291, 0, 0, 0);
        // R5/R6: halfword zero and sign, word zero and sign.
        run_op(2'd1, 1'b0, 1'b0, 1'b0, 16'hFFFE, 64'h2006, 64'd0, 5'd1, 5'd2, 64'h8001_0000_0000_0000, 1, 2, 1);
        run_op(2'd1, 1'b1, 1'b0, 1'b0, 16'h8000, 64'h2006, 64'd0, 5'd1, 5'd2, 64'h8001_0000_0000_0000, 0, 1, 0);
        run_op(2'd2, 1'b0, 1'b1, 1'b0, 16'h0000, 64'h3004, 64'hFFFF_FFFF_FFFF_FFF0, 5'd7, 5'd8,
               64'hF000_0001_0000_0000, 2, 0, 2);
        run_op(2'd2, 1'b1, 1'b1, 1'b1, 16'h1234, 64'h3004, 64'h10, 5'd7, 5'd8,
               64'hF000_0001_0000_0000, 0, 0, 0);
        // R7: doubleword with signed flag set; R4 scaled displacement, low bits ignored.
        run_op(2'd3, 1'b1, 1'b0, 1'b1, 16'h8007, 64'h4000, 64'd0, 5'd9, 5'd10,
               64'hFEDC_BA98_7654_3210, 0, 3, 0);
        run_op(2'd3, 1'b0, 1'b0, 1'b1, 16'h7FFF, 64'hFFFF_FFFF_FFFF_FFF8, 64'd0, 5'd9, 5'd10,
               64'h0123_4567_89AB_CDEF, 0, 0, 0);
        // R10: destination equals base.
        run_op(2'd0, 1'b0, 1'b0, 1'b0, 16'h0004, 64'h5003, 64'd0, 5'd12, 5'd12,
               64'h0000_0000_AB00_0000, 1, 1, 3);
        // Random mix.
        for (int n = 0; n < 400; n++) begin
            logic [1:0]  sz;
            logic [63:0] b;
            logic [4:0]  rt;
            sz = 2'($urandom_range(0, 3));
            b = {$urandom, $urandom};
            b = b & ~((64'd1 << sz) - 64'd1);
            rt = 5'($urandom);
            run_op(sz, 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), b,
                   {$urandom, $urandom}, rt, ($urandom_range(0, 7) == 0) ? rt : 5'($urandom),
                   {$urandom, $urandom}, $urandom_range(0, 3), $urandom_range(0, 3),
                   $urandom_range(0, 3));
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule